// File: doc/BRIEF.md
# Dual-Channel Interval Timer

This peripheral holds two independent 16-bit interval counters behind one small synchronous register port. Both channels are clocked by the same functional clock, and each channel divides that clock by its own power of two before counting. A channel counts up from zero. When its count meets a programmed terminal value, it latches an expiry flag. In periodic mode it then wraps to zero and keeps going. In single-shot mode it disables itself and holds its count.

Software configures a channel through a control word, sets a terminal value, and starts the channel by setting the run bit. It services the level interrupt by writing one to the expiry flag. The live count can be read at any time without disturbing the channel. Reads complete combinationally in the cycle the address is presented; writes take effect at the next rising clock edge.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register of both channels reads 0 and both interrupt outputs are low.
- R2: Channel c (c = 0, 1) occupies byte offsets (c+1)*0x80 + {0x0 control, 0x4 status, 0x8 terminal value, 0xC count}. Any other offset reads 0, and a write to it changes no register.
- R3: Control bit 8 is interrupt enable, bit 5 is run, bit 4 selects single-shot (0 = periodic), and bits [3:0] are the divider code n. These bits read back as written, and all other bits read 0.
- R4: A write that sets run while run is clear resets the count and the divider to 0. With divider code n, the count then advances by one every 2^n clock cycles. The first step lands 2^n cycles after the starting write edge.
- R5: Divider codes 9 to 15 divide by 256, the same as code 8.
- R6: On a count step where count equals the terminal value, status bit 0 sets. In periodic mode the count returns to 0 and the channel keeps running, so the period is (terminal+1)*2^n cycles.
- R7: In single-shot mode, the match step also clears the run bit and the count holds at the terminal value.
- R8: Writing 1 to status bit 0 clears the expiry flag. Writing 0 there leaves it unchanged.
- R9: Each interrupt output is a level equal to that channel's expiry flag ANDed with its interrupt-enable bit.
- R10: Clearing run stops the channel with the count held. The terminal value can be rewritten while stopped and reads back the new value.
- R11: The channels are independent: activity or writes on one channel never change the other channel's count or registers.
- R12: Reading the count register, even on every cycle, does not alter counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 9 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 2 | Per-channel level interrupt |

## Verification
The checks assume that software rewrites a channel's terminal value only while that channel is stopped. Without that, a running count could lie above the terminal value and the bound on the count would not hold. The bench respects this: it always clears the run bit, and then rewrites the terminal value, before each new interval. The flag-clear check assumes the only way to drop the flag is a status write with bit 0 set. The stimulus issues such writes only on stopped channels, so a set never collides with a clear.

// File: rtl/timer_pkg.sv
// Package: shared register offsets, control bit positions and divider limits
// for the dual interval timer. Assumes byte addressing with a 0x80 stride.
package timer_pkg;
    localparam int OFF_W      = 7;
    localparam logic [OFF_W-1:0] OFF_CTRL = 7'h00;
    localparam logic [OFF_W-1:0] OFF_STAT = 7'h04;
    localparam logic [OFF_W-1:0] OFF_TERM = 7'h08;
    localparam logic [OFF_W-1:0] OFF_CNT  = 7'h0C;
    localparam int BIT_IE     = 8;
    localparam int BIT_RUN    = 5;
    localparam int BIT_SHOT   = 4;
    localparam int CODE_W     = 4;
    localparam int MAX_CODE   = 8;
endpackage

// File: rtl/timer_prescaler.sv
// Module: per-channel power-of-two clock divider. Emits a one-cycle tick every
// 2^n enabled cycles, n taken from the code and clamped to MAX_CODE.
// Assumes restart and run are never both needed at once (restart wins).
module timer_prescaler #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int DIV_W = MAX_CODE;

    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  mask;
    logic [CODE_W-1:0] eff;

    // Clamp reserved codes and build the low-bit mask for the chosen ratio.
    always_comb begin
        eff = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(eff));
        end
    end

    assign tick = run && ((div_q & mask) == mask);

    // Free-running divider, cleared on channel start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/timer_channel.sv
// Module: one interval channel with control, flag, terminal and count state.
// Counts up on prescaled ticks, flags on match, wraps or stops by mode.
// Assumes CNT_W <= DATA_W and that the strobes are already address-decoded.
module timer_channel
    import timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              stat_wr,
    input  logic              term_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              run,
    output logic              shot,
    output logic              ie,
    output logic              flag,
    output logic [CNT_W-1:0]  term,
    output logic [CNT_W-1:0]  count,
    output logic              irq
);
    logic              ie_q, run_q, shot_q, flag_q;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  term_q, cnt_q;
    logic              start, tick, match;

    assign start = ctrl_wr && wdata[BIT_RUN] && !run_q;
    assign match = tick && (cnt_q == term_q);

    timer_prescaler #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .restart (start),
        .code    (code_q),
        .tick    (tick)
    );

    // Control word: software writes win, single-shot match drops run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            run_q  <= 1'b0;
            shot_q <= 1'b0;
            code_q <= '0;
        end else if (ctrl_wr) begin
            ie_q   <= wdata[BIT_IE];
            run_q  <= wdata[BIT_RUN];
            shot_q <= wdata[BIT_SHOT];
            code_q <= wdata[CODE_W-1:0];
        end else if (match && shot_q) begin
            run_q  <= 1'b0;
        end
    end

    // Terminal value register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_q <= '0;
        end else if (term_wr) begin
            term_q <= wdata[CNT_W-1:0];
        end
    end

    // Up counter: cleared on start, wraps in periodic mode, holds in single-shot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (!match) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (!shot_q) begin
                cnt_q <= '0;
            end
        end
    end

    // Expiry flag: set on match, cleared by writing one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (match) begin
            flag_q <= 1'b1;
        end else if (stat_wr && wdata[0]) begin
            flag_q <= 1'b0;
        end
    end

    // Readback image of the control word.
    always_comb begin
        ctrl_word             = '0;
        ctrl_word[BIT_IE]     = ie_q;
        ctrl_word[BIT_RUN]    = run_q;
        ctrl_word[BIT_SHOT]   = shot_q;
        ctrl_word[CODE_W-1:0] = code_q;
    end

    assign run   = run_q;
    assign shot  = shot_q;
    assign ie    = ie_q;
    assign flag  = flag_q;
    assign term  = term_q;
    assign count = cnt_q;
    assign irq   = flag_q & ie_q;
endmodule

// File: rtl/dual_interval_timer.sv
// Module: top of the interval timer. Decodes the register port onto NUM_CH
// channels at a 0x80 stride starting at 0x80 and merges their read data.
// Assumes ADDR_W leaves room for NUM_CH+1 blocks of 0x80 bytes.
module dual_interval_timer
    import timer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int SEL_W = ADDR_W - OFF_W;

    logic [OFF_W-1:0]              off;
    logic [NUM_CH-1:0]             hit, ctrl_wr, stat_wr, term_wr;
    logic [NUM_CH-1:0]             ch_run, ch_shot, ch_ie, ch_flag;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_term, ch_count;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_ctrl, ch_rd;

    assign off = bus_addr[OFF_W-1:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign hit[c]     = (bus_addr[ADDR_W-1:OFF_W] == SEL_W'(c + 1));
        assign ctrl_wr[c] = bus_we && hit[c] && (off == OFF_CTRL);
        assign stat_wr[c] = bus_we && hit[c] && (off == OFF_STAT);
        assign term_wr[c] = bus_we && hit[c] && (off == OFF_TERM);

        timer_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_wr   (ctrl_wr[c]),
            .stat_wr   (stat_wr[c]),
            .term_wr   (term_wr[c]),
            .wdata     (bus_wdata),
            .ctrl_word (ch_ctrl[c]),
            .run       (ch_run[c]),
            .shot      (ch_shot[c]),
            .ie        (ch_ie[c]),
            .flag      (ch_flag[c]),
            .term      (ch_term[c]),
            .count     (ch_count[c]),
            .irq       (irq[c])
        );

        // Per-channel read word, zero when the address misses this channel.
        always_comb begin
            ch_rd[c] = '0;
            if (hit[c]) begin
                case (off)
                    OFF_CTRL: ch_rd[c] = ch_ctrl[c];
                    OFF_STAT: ch_rd[c] = DATA_W'(ch_flag[c]);
                    OFF_TERM: ch_rd[c] = DATA_W'(ch_term[c]);
                    OFF_CNT:  ch_rd[c] = DATA_W'(ch_count[c]);
                    default:  ch_rd[c] = '0;
                endcase
            end
        end
    end

    // Merge the per-channel read words; at most one is non-zero.
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            bus_rdata = bus_rdata | ch_rd[c];
        end
    end
endmodule

// File: rtl/timer_checker.sv
// Module: assertion checker bound to the timer top. Assumes terminal values
// are rewritten only while the owning channel is stopped.
module timer_checker #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH-1:0]        run,
    input logic [NUM_CH-1:0]        shot,
    input logic [NUM_CH-1:0]        ie,
    input logic [NUM_CH-1:0]        flag,
    input logic [NUM_CH-1:0]        irq,
    input logic [NUM_CH-1:0]        ctrl_wr,
    input logic [NUM_CH-1:0]        stat_wr,
    input logic                     wdata0,
    input logic [NUM_CH-1:0][CNT_W-1:0] count,
    input logic [NUM_CH-1:0][CNT_W-1:0] term
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_count_within_term_R6: assert property (@(posedge clk) disable iff (!rst_n)
            run[c] |-> (count[c] <= term[c]));

        assert_flag_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[c]) |-> ($past(run[c]) && ($past(count[c]) == $past(term[c]))));

        assert_shot_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(run[c]) && !$past(ctrl_wr[c])) |-> ($past(shot[c]) && flag[c]));

        assert_stopped_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[c] && $past(!run[c])) |-> $stable(count[c]));

        assert_flag_clear_w1_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag[c]) |-> ($past(stat_wr[c]) && $past(wdata0)));

        assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[c]) |-> ($rose(flag[c]) || $rose(ie[c])));
    end
endmodule

bind dual_interval_timer timer_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ch_run),
    .shot    (ch_shot),
    .ie      (ch_ie),
    .flag    (ch_flag),
    .irq     (irq),
    .ctrl_wr (ctrl_wr),
    .stat_wr (stat_wr),
    .wdata0  (bus_wdata[0]),
    .count   (ch_count),
    .term    (ch_term)
);

// File: tb/dual_interval_timer_test.sv
`timescale 1ns/100ps
module dual_interval_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    dual_interval_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #2 clk = ~clk;

    function automatic int base(input int ch);
        return (ch + 1) * 128;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(input int a, input int d);
        @(negedge clk);
        bus_addr  = 9'(a);
        bus_wdata = 16'(d);
        bus_we    = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic bus_read(input int a, output int d);
        @(negedge clk);
        bus_addr = 9'(a);
        bus_we   = 1'b0;
        #0.5 d = int'(bus_rdata);
    endtask

    // Start a channel and follow its count every cycle against the model.
    task automatic run_and_track(input int ch, input int code, input int term,
                                 input int shot, input int ie, input int cycles);
        int n, m, exp;
        n = (code > 8) ? 8 : code;
        bus_write(base(ch) + 0, (ie << 8) | (1 << 5) | (shot << 4) | code);
        bus_addr = 9'(base(ch) + 12);
        #0.5 check("R4 count cleared on start", int'(bus_rdata), 0);
        for (int j = 1; j <= cycles; j++) begin
            @(posedge clk);
            #1;
            m = j >> n;
            if (shot != 0) exp = (m <= term) ? m : term;
            else           exp = m % (term + 1);
            check("R4/R6/R7/R12 count per cycle", int'(bus_rdata), exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int d, other_before, other_after, c0, c1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values of every register and interrupt.
        for (int ch = 0; ch < 2; ch++) begin
            for (int r = 0; r < 4; r++) begin
                bus_read(base(ch) + 4 * r, d);
                check("R1 reset register", d, 0);
            end
        end
        check("R1 reset irq", int'(irq), 0);

        // R2: unmapped offsets read zero and ignore writes.
        bus_write(9'h000, 16'hFFFF);
        bus_write(9'h090, 16'hFFFF);
        bus_write(9'h180, 16'hFFFF);
        bus_write(9'h10C + 4, 16'hFFFF);
        bus_read(9'h000, d); check("R2 unmapped read 0x000", d, 0);
        bus_read(9'h090, d); check("R2 unmapped read 0x090", d, 0);
        bus_read(9'h180, d); check("R2 unmapped read 0x180", d, 0);
        for (int ch = 0; ch < 2; ch++) begin
            for (int r = 0; r < 4; r++) begin
                bus_read(base(ch) + 4 * r, d);
                check("R2 register untouched by unmapped write", d, 0);
            end
        end

        // R3: control bits read back, other bits read zero.
        bus_write(base(0), 16'hFFDF);
        bus_read(base(0), d); check("R3 control readback", d, 16'h011F);
        bus_read(base(1), d); check("R11 other control untouched", d, 0);
        bus_write(base(0), 0);
        bus_read(base(0), d); check("R3 control cleared", d, 0);

        // Sweep channels, modes, divider codes and terminal values.
        for (int ch = 0; ch < 2; ch++) begin
            for (int shot = 0; shot < 2; shot++) begin
                for (int code = 0; code < 4; code++) begin
                    for (int ti = 0; ti < 4; ti++) begin
                        int term, ie, cyc;
                        term = (ti == 3) ? 5 : ti;
                        ie   = term % 2;
                        cyc  = 2 * (term + 1) * (1 << code) + 3;
                        bus_write(base(ch) + 8, term);
                        bus_read(base(ch) + 8, d);
                        check("R10 terminal rewritten while stopped", d, term);
                        bus_read(base(1 - ch) + 12, other_before);
                        run_and_track(ch, code, term, shot, ie, cyc);
                        bus_read(base(ch) + 4, d);
                        check("R6 expiry flag set", d, 1);
                        check("R9 irq level", int'(irq[ch]), ie);
                        check("R9 other irq low", int'(irq[1 - ch]), 0);
                        bus_read(base(ch), d);
                        check("R7 run bit after interval", (d >> 5) & 1, (shot != 0) ? 0 : 1);
                        // R10: stop and confirm the count holds.
                        bus_write(base(ch), (ie << 8) | (shot << 4) | code);
                        bus_read(base(ch) + 12, c0);
                        repeat (5) @(posedge clk);
                        bus_read(base(ch) + 12, c1);
                        check("R10 count holds when stopped", c1, c0);
                        if (shot != 0) check("R7 count holds at terminal", c1, term);
                        bus_read(base(1 - ch) + 12, other_after);
                        check("R11 other channel count unchanged", other_after, other_before);
                        // R8: writing zero keeps the flag, writing one clears it.
                        bus_write(base(ch) + 4, 0);
                        bus_read(base(ch) + 4, d);
                        check("R8 write zero keeps flag", d, 1);
                        bus_write(base(ch) + 4, 1);
                        bus_read(base(ch) + 4, d);
                        check("R8 write one clears flag", d, 0);
                        check("R9 irq low after clear", int'(irq[ch]), 0);
                    end
                end
            end
        end

        // R5: reserved divider code behaves as divide-by-256.
        bus_write(base(0) + 8, 1);
        run_and_track(0, 11, 1, 0, 0, 2 * 256 + 4);
        bus_read(base(0) + 4, d);
        check("R5 reserved code expiry", d, 1);
        bus_write(base(0), 0);
        bus_write(base(0) + 4, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule